// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings one 16-bit single-data-rate SDRAM from power-up to a usable state. After a start strobe it holds the command bus at NOP for a power-up window sized in microseconds. It then closes all banks with one precharge and issues a configurable number of auto-refresh commands. Last, it writes the mode register, raises a sticky ready level, and from then on pulses a refresh request at the operating refresh interval. Every wait between commands is given in nanoseconds and turned into clock cycles at elaboration. The conversion rounds up and never gives less than two cycles.

One refresh timer serves both phases. While the device is being set up, it runs at a short initialization interval, and each auto-refresh waits for the timer to expire. When the mode register has been written, the timer is reloaded with the operating interval, less one cycle as margin. With the default 250 MHz clock the waits are:

| Wait | Nanoseconds | Cycles |
|---|---|---|
| tRP | 20 | 5 |
| tRFC | 66 | 17 |
| tMRD | 20 | 5 |
| Initialization interval | 100 | 25 |
| Operating interval | 7812 | 1952 |

The default power-up window is 25000 cycles. For the longer JEDEC-style sequence, set the power-up wait to 200 µs and the refresh count to 8.

Top module: `sdram_init_seq`

## Requirements
- R1: Out of reset and until start_i is seen, the outputs hold these values: cs_n_o=1, ras_n_o=1, cas_n_o=1, we_n_o=1, addr_o=0, ba_o=0, init_done_o=0 and refresh_req_o=0. cke_o is 1 at all times.
- R2: PRECHARGE ALL appears no earlier than PWRUP_US×CLK_MHZ cycles after start_i. Every cycle before it is a NOP.
- R3: A command is any cycle with cs_n_o=0. Exactly one PRECHARGE ALL appears, then exactly NUM_REF AUTO REFRESH, then exactly one LOAD MODE, in that order. No command follows LOAD MODE.
- R4: The commands are encoded on {ras_n,cas_n,we_n} as follows.
  - PRECHARGE ALL is 010, with addr_o bit AP_BIT (10) set to 1.
  - AUTO REFRESH is 001.
  - LOAD MODE is 000, with addr_o=MODE_VAL (0x023: burst 8, sequential, CAS latency 2) and ba_o=0.
  - NOP drives cs_n=1 with ras_n, cas_n and we_n all at 1.
- R5: The first AUTO REFRESH follows PRECHARGE ALL after at least ceil(tRP·f) cycles. That gap is a whole multiple of the initialization interval ceil(100 ns·f) cycles.
- R6: Consecutive AUTO REFRESH commands are at least ceil(tRFC·f) cycles apart, and each gap is a whole multiple of the initialization interval. LOAD MODE follows the last AUTO REFRESH by exactly ceil(tRFC·f)+1 cycles.
- R7: init_done_o rises exactly ceil(tMRD·f) cycles after LOAD MODE and then stays high.
- R8: refresh_req_o is low until init_done_o is high. It pulses for single cycles. The first pulse comes ceil(7812 ns·f)−1 cycles after init_done_o rises, and the pulses repeat at that same period.
- R9: A start_i pulse after the first one has no effect: the command sequence is not restarted and no extra command appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts the sequence, honoured once |
| cke_o | output | 1 | Clock enable, always high |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank address |
| addr_o | output | ADDR_W | Address lines |
| init_done_o | output | 1 | Device ready, sticky |
| refresh_req_o | output | 1 | One-cycle periodic refresh request |

## Verification
The command, address and bank outputs are registered, so every pin change lags the sequencer's decision by one cycle. The fixed gaps are therefore exact with the defaults:

- PRECHARGE ALL to the first AUTO REFRESH, and AUTO REFRESH to AUTO REFRESH: 25 cycles.
- Last AUTO REFRESH to LOAD MODE: 18 cycles.
- LOAD MODE to init_done_o: 5 cycles.
- init_done_o to each refresh_req_o pulse, and pulse to pulse: 1952 cycles.
- start_i to PRECHARGE ALL: at least 25000 cycles (50000 for the JEDEC-style instance).

The bench keeps a cycle count that advances on each rising edge and samples all outputs on the falling edge. It timestamps each decoded command and edge, then compares the gaps with values derived from the nanosecond parameters by its own rounding function. Extra start pulses are driven at random times during and after the sequence, and the order checks would catch any restart.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_AREF,
    CMD_MRS
  } sdram_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_PRE,
    ST_TRP,
    ST_AREF,
    ST_TRFC,
    ST_MRS,
    ST_TMRD,
    ST_READY
  } init_state_e;

  // round up, never below two clocks
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c < 2) ? 2 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned AP_BIT = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL = 'h023
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sdram_cmd_e        cmd_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_o  <= 1'b1;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      ba_o    <= '0;
      addr_o  <= '0;
    end else begin
      ba_o <= '0;
      unique case (cmd_i)
        CMD_PRE: begin
          {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b0010;
          addr_o <= AP_MASK;
        end
        CMD_AREF: begin
          {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b0001;
          addr_o <= '0;
        end
        CMD_MRS: begin
          {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b0000;
          addr_o <= MODE_VAL;
        end
        default: begin
          {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b1111;
          addr_o <= '0;
        end
      endcase
    end
  end

  assert_cmd_has_ras_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> !ras_n_o);

  assert_nop_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (ras_n_o && cas_n_o && we_n_o));

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int unsigned INIT_CYC = 25,
  parameter int unsigned OPER_CYC = 1952,
  parameter int unsigned W        = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_init_i,
  input  logic load_oper_i,
  output logic tick_o,
  output logic oper_o
);

  logic [W-1:0] cnt_q, ival_q;
  logic         run_q;

  assign tick_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ival_q <= '0;
      run_q  <= 1'b0;
      oper_o <= 1'b0;
    end else if (load_init_i) begin
      cnt_q  <= W'(INIT_CYC - 1);
      ival_q <= W'(INIT_CYC - 1);
      run_q  <= 1'b1;
      oper_o <= 1'b0;
    end else if (load_oper_i) begin
      cnt_q  <= W'(OPER_CYC - 1);
      ival_q <= W'(OPER_CYC - 1);
      oper_o <= 1'b1;
    end else if (run_q) begin
      cnt_q <= tick_o ? ival_q : cnt_q - 1'b1;
    end
  end

  assert_tick_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !load_init_i && !load_oper_i) |=> !tick_o);

  assert_oper_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oper_o && !load_init_i) |=> oper_o);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned PWR_CYC = 25000,
  parameter int unsigned RP_CYC  = 5,
  parameter int unsigned RFC_CYC = 17,
  parameter int unsigned MRD_CYC = 5,
  parameter int unsigned NUM_REF = 2,
  parameter int unsigned CNT_W   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       ref_tick_i,
  output sdram_cmd_e cmd_o,
  output logic       load_init_o,
  output logic       load_oper_o,
  output logic       init_done_o
);

  localparam int unsigned RW = $clog2(NUM_REF + 1);

  init_state_e      state_q, state_d;
  logic [CNT_W-1:0] wait_q, wait_d;
  logic [RW-1:0]    ref_q, ref_d;

  always_comb begin
    state_d     = state_q;
    wait_d      = wait_q;
    ref_d       = ref_q;
    cmd_o       = CMD_NOP;
    load_init_o = 1'b0;
    load_oper_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_PWRUP;
        wait_d  = CNT_W'(PWR_CYC - 1);
      end
      ST_PWRUP: begin
        if (wait_q == '0) state_d = ST_PRE;
        else wait_d = wait_q - 1'b1;
      end
      ST_PRE: begin
        cmd_o       = CMD_PRE;
        load_init_o = 1'b1;
        wait_d      = CNT_W'(RP_CYC - 1);
        state_d     = ST_TRP;
      end
      ST_TRP: begin
        if (wait_q == '0) state_d = ST_AREF;
        else wait_d = wait_q - 1'b1;
      end
      ST_AREF: if (ref_tick_i) begin
        cmd_o   = CMD_AREF;
        ref_d   = ref_q + 1'b1;
        wait_d  = CNT_W'(RFC_CYC - 1);
        state_d = ST_TRFC;
      end
      ST_TRFC: begin
        if (wait_q == '0) state_d = (ref_q == RW'(NUM_REF)) ? ST_MRS : ST_AREF;
        else wait_d = wait_q - 1'b1;
      end
      ST_MRS: begin
        cmd_o   = CMD_MRS;
        wait_d  = CNT_W'(MRD_CYC - 1);
        state_d = ST_TMRD;
      end
      ST_TMRD: begin
        if (wait_q == '0) begin
          state_d     = ST_READY;
          load_oper_o = 1'b1;
        end else wait_d = wait_q - 1'b1;
      end
      ST_READY: ;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wait_q      <= '0;
      ref_q       <= '0;
      init_done_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      wait_q      <= wait_d;
      ref_q       <= ref_d;
      init_done_o <= (state_d == ST_READY);
    end
  end

  assert_mrs_after_refs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS) |-> (ref_q == RW'(NUM_REF)));

  assert_aref_bounded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_AREF) |-> (ref_q < RW'(NUM_REF)));

  assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  assert_no_cmd_when_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (cmd_o == CMD_NOP));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned PWRUP_US    = 100,
  parameter int unsigned NUM_REF     = 2,
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned BANK_W      = 2,
  parameter int unsigned AP_BIT      = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL = 'h023,
  parameter int unsigned T_RP_NS     = 20,
  parameter int unsigned T_RFC_NS    = 66,
  parameter int unsigned T_MRD_NS    = 20,
  parameter int unsigned INIT_REF_NS = 100,
  parameter int unsigned OPER_REF_NS = 7812
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o,
  output logic              refresh_req_o
);

  localparam int unsigned PWR_CYC  = PWRUP_US * CLK_MHZ;
  localparam int unsigned RP_CYC   = ns_to_cyc(T_RP_NS, CLK_MHZ);
  localparam int unsigned RFC_CYC  = ns_to_cyc(T_RFC_NS, CLK_MHZ);
  localparam int unsigned MRD_CYC  = ns_to_cyc(T_MRD_NS, CLK_MHZ);
  localparam int unsigned INIT_CYC = ns_to_cyc(INIT_REF_NS, CLK_MHZ);
  localparam int unsigned OPER_CYC = max2(ns_to_cyc(OPER_REF_NS, CLK_MHZ) - 1, 2);
  localparam int unsigned CNT_W    = $clog2(max2(PWR_CYC, OPER_CYC) + 1);

  sdram_cmd_e cmd;
  logic       load_init, load_oper, tick, oper;

  assign cke_o = 1'b1;

  sdram_init_fsm #(
    .PWR_CYC(PWR_CYC), .RP_CYC(RP_CYC), .RFC_CYC(RFC_CYC),
    .MRD_CYC(MRD_CYC), .NUM_REF(NUM_REF), .CNT_W(CNT_W)
  ) i_fsm (
    .clk_i, .rst_ni, .start_i,
    .ref_tick_i (tick),
    .cmd_o      (cmd),
    .load_init_o(load_init),
    .load_oper_o(load_oper),
    .init_done_o
  );

  sdram_refresh_timer #(
    .INIT_CYC(INIT_CYC), .OPER_CYC(OPER_CYC), .W(CNT_W)
  ) i_timer (
    .clk_i, .rst_ni,
    .load_init_i(load_init),
    .load_oper_i(load_oper),
    .tick_o     (tick),
    .oper_o     (oper)
  );

  sdram_cmd_enc #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT), .MODE_VAL(MODE_VAL)
  ) i_enc (
    .clk_i, .rst_ni,
    .cmd_i(cmd),
    .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o, .ba_o, .addr_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) refresh_req_o <= 1'b0;
    else         refresh_req_o <= tick && oper;
  end

  assert_req_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_req_o |-> init_done_o);

  assert_mrs_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !ras_n_o && !cas_n_o && !we_n_o) |-> (addr_o == MODE_VAL && ba_o == '0));

  assert_pre_ap_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !ras_n_o && cas_n_o && !we_n_o) |-> addr_o[AP_BIT]);

endmodule

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/1ps

module sdram_init_mon #(
  parameter int    PWR  = 25000,
  parameter int    NREF = 2,
  parameter int    RP   = 5,
  parameter int    RFC  = 17,
  parameter int    MRD  = 5,
  parameter int    INIT = 25,
  parameter int    OPER = 1952,
  parameter int    MODE = 'h23,
  parameter string TAG  = "base"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  int          cyc,
  input  logic        start,
  input  logic        cke,
  input  logic        cs_n,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic [1:0]  ba,
  input  logic [12:0] addr,
  input  logic        done,
  input  logic        req,
  output int          n_chk,
  output int          n_bad,
  output logic        fin
);

  int chk_q = 0, bad_q = 0;
  int phase = 0, ar_cnt = 0, pre_cnt = 0, n_req = 0;
  int t_start = 0, t_pre = 0, t_ar = 0, t_mrs = 0, t_done = 0, t_req = 0;
  int nop_bad = 0, cke_bad = 0, req_double = 0;
  bit r1_done = 0, done_prev = 0, req_prev = 0, done_fell = 0, fin_q = 0;

  assign n_chk = chk_q;
  assign n_bad = bad_q;
  assign fin   = fin_q;

  task automatic chk(input bit ok, input string r, input string what,
                     input longint act, input longint exp);
    chk_q++;
    if (!ok) begin
      bad_q++;
      $display("FAIL %s %s [%s]: actual %0d expected %0d", r, what, TAG, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !fin_q) begin
    if (!r1_done) begin
      r1_done = 1;
      // R1 reset state
      chk({cke, cs_n, ras_n, cas_n, we_n, done, req} == 7'b1111100 && addr == 0 && ba == 0,
          "R1", "reset pins {cke,cs,ras,cas,we,done,req}",
          {cke, cs_n, ras_n, cas_n, we_n, done, req}, 7'b1111100);
    end
    if (cs_n && !(ras_n && cas_n && we_n)) nop_bad++;
    if (!cke) cke_bad++;
    if (phase == 0 && start) begin
      t_start = cyc;
      phase   = 1;
    end
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b010: begin
          pre_cnt++;
          chk(phase == 1, "R3 R9", "precharge phase", phase, 1);
          chk(addr[10], "R4", "precharge A10", addr[10], 1);
          chk(cyc - t_start >= PWR, "R2", "start to precharge gap", cyc - t_start, PWR);
          t_pre = cyc;
          phase = 2;
        end
        3'b001: begin
          chk(phase == 2 && ar_cnt < NREF, "R3 R9", "refresh order (count so far)", ar_cnt, NREF - 1);
          if (ar_cnt == 0)
            chk(cyc - t_pre >= RP && (cyc - t_pre) % INIT == 0, "R5", "precharge to refresh gap",
                cyc - t_pre, INIT);
          else
            chk(cyc - t_ar >= RFC && (cyc - t_ar) % INIT == 0, "R6", "refresh to refresh gap",
                cyc - t_ar, INIT);
          t_ar = cyc;
          ar_cnt++;
        end
        3'b000: begin
          chk(phase == 2 && ar_cnt == NREF, "R3", "mode load after refreshes", ar_cnt, NREF);
          chk(addr == 13'(MODE) && ba == 0, "R4", "mode value on address", addr, MODE);
          chk(cyc - t_ar == RFC + 1, "R6", "last refresh to mode gap", cyc - t_ar, RFC + 1);
          t_mrs = cyc;
          phase = 3;
        end
        default: chk(0, "R4", "unknown command code", {ras_n, cas_n, we_n}, 0);
      endcase
      if (phase == 4) chk(0, "R3 R9", "command after ready", {ras_n, cas_n, we_n}, 7);
    end
    if (done && !done_prev) begin
      chk(phase == 3, "R7", "ready phase", phase, 3);
      chk(cyc - t_mrs == MRD, "R7", "mode to ready gap", cyc - t_mrs, MRD);
      t_done = cyc;
      phase  = 4;
    end
    if (!done && done_prev) done_fell = 1;
    done_prev = done;
    if (req) begin
      if (req_prev) req_double++;
      else begin
        chk(phase == 4, "R8", "request before ready", phase, 4);
        if (n_req == 0)
          chk(cyc - t_done == OPER, "R8", "ready to first request", cyc - t_done, OPER);
        else
          chk(cyc - t_req == OPER, "R8", "request period", cyc - t_req, OPER);
        t_req = cyc;
        n_req++;
      end
    end
    req_prev = req;
    if (n_req >= 3 && !req) begin
      chk(nop_bad == 0, "R4", "NOP cycles with strobes low", nop_bad, 0);
      chk(cke_bad == 0, "R1", "cycles with cke low", cke_bad, 0);
      chk(!done_fell, "R7", "ready dropped", done_fell, 0);
      chk(req_double == 0, "R8", "multi-cycle request", req_double, 0);
      chk(pre_cnt == 1, "R9", "precharge count", pre_cnt, 1);
      chk(ar_cnt == NREF, "R3", "refresh count", ar_cnt, NREF);
      fin_q = 1;
    end
  end

endmodule

module test_sdram_init_seq;

  function automatic int cyc_of(int ns);
    int c;
    c = (ns * 250 + 999) / 1000;
    return (c < 2) ? 2 : c;
  endfunction

  localparam int E_RP   = cyc_of(20);
  localparam int E_RFC  = cyc_of(66);
  localparam int E_MRD  = cyc_of(20);
  localparam int E_INIT = cyc_of(100);
  localparam int E_OPER = cyc_of(7812) - 1;

  logic clk = 0;
  logic rst_n = 0;
  int   cyc = 0;
  logic start_a = 0, start_b = 0;

  logic        cke_a, cs_a, ras_a, cas_a, we_a, done_a, req_a;
  logic [1:0]  ba_a;
  logic [12:0] addr_a;
  logic        cke_b, cs_b, ras_b, cas_b, we_b, done_b, req_b;
  logic [1:0]  ba_b;
  logic [12:0] addr_b;

  int   chk_a, bad_a, chk_b, bad_b;
  logic fin_a, fin_b;
  int   wd_bad = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_init_seq i_sdram_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_a),
    .cke_o(cke_a), .cs_n_o(cs_a), .ras_n_o(ras_a), .cas_n_o(cas_a), .we_n_o(we_a),
    .ba_o(ba_a), .addr_o(addr_a), .init_done_o(done_a), .refresh_req_o(req_a)
  );

  sdram_init_seq #(.PWRUP_US(200), .NUM_REF(8)) i_sdram_init_seq_jedec (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b),
    .cke_o(cke_b), .cs_n_o(cs_b), .ras_n_o(ras_b), .cas_n_o(cas_b), .we_n_o(we_b),
    .ba_o(ba_b), .addr_o(addr_b), .init_done_o(done_b), .refresh_req_o(req_b)
  );

  sdram_init_mon #(.PWR(25000), .NREF(2), .RP(E_RP), .RFC(E_RFC), .MRD(E_MRD),
                   .INIT(E_INIT), .OPER(E_OPER), .MODE('h23), .TAG("base")) i_mon_a (
    .clk, .rst_n, .cyc, .start(start_a), .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a),
    .cas_n(cas_a), .we_n(we_a), .ba(ba_a), .addr(addr_a), .done(done_a), .req(req_a),
    .n_chk(chk_a), .n_bad(bad_a), .fin(fin_a)
  );

  sdram_init_mon #(.PWR(50000), .NREF(8), .RP(E_RP), .RFC(E_RFC), .MRD(E_MRD),
                   .INIT(E_INIT), .OPER(E_OPER), .MODE('h23), .TAG("jedec")) i_mon_b (
    .clk, .rst_n, .cyc, .start(start_b), .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b),
    .cas_n(cas_b), .we_n(we_b), .ba(ba_b), .addr(addr_b), .done(done_b), .req(req_b),
    .n_chk(chk_b), .n_bad(bad_b), .fin(fin_b)
  );

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
  end

  initial begin : drv_a
    wait (rst_n);
    repeat (5 + $urandom_range(15)) @(posedge clk);
    #1 start_a = 1;
    @(posedge clk);
    #1 start_a = 0;
    // R9: spurious starts during and after the sequence
    for (int k = 0; k < 40; k++) begin
      repeat ($urandom_range(2000, 50)) @(posedge clk);
      #1 start_a = 1;
      @(posedge clk);
      #1 start_a = 0;
    end
  end

  initial begin : drv_b
    wait (rst_n);
    repeat (5 + $urandom_range(15)) @(posedge clk);
    #1 start_b = 1;
    @(posedge clk);
    #1 start_b = 0;
    // R9: held start for two cycles, then random pulses
    repeat (3) @(posedge clk);
    #1 start_b = 1;
    repeat (2) @(posedge clk);
    #1 start_b = 0;
    for (int k = 0; k < 40; k++) begin
      repeat ($urandom_range(2500, 100)) @(posedge clk);
      #1 start_b = 1;
      @(posedge clk);
      #1 start_b = 0;
    end
  end

  initial begin : finish_ctl
    wait (rst_n);
    while (!(fin_a && fin_b) && cyc < 150000) @(negedge clk);
    if (!(fin_a && fin_b)) begin
      wd_bad = 1;
      $display("FAIL watchdog R3: actual fin %0d%0d expected 11", fin_a, fin_b);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             chk_a + chk_b + 1, bad_a + bad_b + wd_bad);
    $finish;
  end

endmodule